// File: doc/BRIEF.md
# Fracturable Lookup-Table Logic Cluster

This block is a cluster of eight configurable lookup tables. Each table stores a 64-entry truth table. At run time the table works in one of two ways. It can be one function of six inputs, or it can be two separate functions of five inputs that share the same five inputs. Every table input picks its source bit from a shared block input bus, so one cluster can implement any eight 6-input functions of bus bits, or sixteen 5-input ones.

Configuration enters through an addressed port: a table index, a word select and a 16-bit data word. Writes land in a hidden shadow copy. A single commit strobe moves the shadow contents of all tables into the active copy in the same clock edge, so outputs never show a partly loaded table. A per-table control bit chooses whether that table's outputs come straight from the lookup or from an output register that lags by one clock. A typical use is a code converter, for example turning a thermometer code from a quantiser into a binary count.

Top module: `flut_cluster`

## Requirements
- R1: After reset every active truth table, mode bit, register bit and input select is zero, so both outputs of every table read 0.
- R2: In whole mode (split bit 0) table i drives `out_a[i]` = T[x], where x = {x5..x0} is the 6-bit table input index. It drives `out_b[i]` = 0.
- R3: In split mode (split bit 1) `out_a[i]` = T[{0,x4..x0}] and `out_b[i]` = T[32 + {x4..x0}]. Table input x5 has no effect on either output.
- R4: Table input k is the block bus bit `blk_in[s_k]`, where s_k is a 4-bit select. Word 5 holds s0 in bits 3:0, s1 in 7:4, s2 in 11:8 and s3 in 15:12. Word 6 holds s4 in bits 3:0 and s5 in bits 7:4.
- R5: Word select w from 0 to 3 loads truth-table bits 16w+15 down to 16w. Word 4 bit 0 is the split bit and word 4 bit 1 is the register bit.
- R6: A write changes only the shadow copy of the addressed table, and outputs do not change until a commit pulse. At the commit edge every table's active copy takes its shadow value from before that edge, all tables at once.
- R7: With the register bit set, a table's outputs show the lookup result of the inputs present at the previous rising clock edge.
- R8: With the register bit clear, a table's outputs follow its inputs combinationally within the same cycle.
- R9: A write to word select 7 changes no state, and the outputs stay as they were after a following commit.
- R10: Three tables in whole mode, with truth tables set to the bits of the population count, convert a 6-bit thermometer code into its 3-bit binary count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_in | input | 16 | Block input bus feeding the input selectors |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_lut | input | 3 | Index of the table being written |
| cfg_word | input | 3 | Word select inside the table |
| cfg_data | input | 16 | Configuration write data |
| cfg_commit | input | 1 | Copies all shadow contents into the active set |
| out_a | output | 8 | First output of each table |
| out_b | output | 8 | Second output of each table (split mode only) |

## Verification
A wrong bit in an active truth table appears at the output as soon as an input pattern selects that entry. Random bus patterns usually reach it within a few dozen vectors. A wrong select or mode bit corrupts a large fraction of patterns at once, and a shadow copy that leaks early shows up in the cycle after the write, before any commit. A latency fault in the output register is seen on the first vector that differs from its predecessor. The bench therefore checks the registered tables both before and after each edge.

// File: rtl/flut_pkg.sv
package flut_pkg;
    localparam int LUT_K        = 6;
    localparam int CFG_DW       = 16;
    localparam int BUS_W        = 16;
    localparam int WORD_AW      = 3;
    localparam int TT_BITS      = 1 << LUT_K;
    localparam int TT_WORDS     = TT_BITS / CFG_DW;
    localparam int SEL_W        = $clog2(BUS_W);
    localparam int SEL_PER_WORD = CFG_DW / SEL_W;
    localparam int CTL_WORD     = TT_WORDS;
    localparam int SEL_BASE     = TT_WORDS + 1;

    typedef struct packed {
        logic [TT_BITS-1:0]              tt;
        logic                            split;
        logic                            reg_en;
        logic [LUT_K-1:0][SEL_W-1:0]     sel;
    } lut_cfg_t;

    typedef struct packed {
        lut_cfg_t shd;
        lut_cfg_t act;
    } cfg_state_t;

    typedef struct packed {
        logic a;
        logic b;
    } lut_out_t;
endpackage

// File: rtl/flut_cfg_store.sv
module flut_cfg_store
    import flut_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WORD_AW-1:0]  word,
    input  logic [CFG_DW-1:0]   data,
    input  logic                commit,
    output lut_cfg_t            active
);
    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int w = 0; w < TT_WORDS; w++) begin
                if (word == WORD_AW'(w))
                    st_d.shd.tt[w*CFG_DW +: CFG_DW] = data;
            end
            if (word == WORD_AW'(CTL_WORD)) begin
                st_d.shd.split  = data[0];
                st_d.shd.reg_en = data[1];
            end
            for (int k = 0; k < LUT_K; k++) begin
                if (word == WORD_AW'(SEL_BASE + k / SEL_PER_WORD))
                    st_d.shd.sel[k] = data[(k % SEL_PER_WORD)*SEL_W +: SEL_W];
            end
        end
        if (commit)
            st_d.act = st_q.shd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.act;

    // R6: active set holds without a commit
    a_r6_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(st_q.act));

    // R6: commit copies the pre-edge shadow
    a_r6_commit_copies: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (st_q.act == $past(st_q.shd)));
endmodule

// File: rtl/flut_cell.sv
module flut_cell
    import flut_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  lut_cfg_t          cfg,
    input  logic [BUS_W-1:0]  blk_in,
    output logic              out_a,
    output logic              out_b
);
    logic [LUT_K-1:0]   x;
    logic [LUT_K-2:0]   lo;
    lut_out_t           look;
    lut_out_t           oreg_d, oreg_q;

    always_comb begin
        for (int k = 0; k < LUT_K; k++)
            x[k] = blk_in[cfg.sel[k]];
    end

    assign lo = x[LUT_K-2:0];

    always_comb begin
        if (cfg.split) begin
            look.a = cfg.tt[{1'b0, lo}];
            look.b = cfg.tt[{1'b1, lo}];
        end else begin
            look.a = cfg.tt[x];
            look.b = 1'b0;
        end
    end

    always_comb begin
        oreg_d = look;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) oreg_q <= '0;
        else        oreg_q <= oreg_d;
    end

    assign out_a = cfg.reg_en ? oreg_q.a : look.a;
    assign out_b = cfg.reg_en ? oreg_q.b : look.b;

    // R2: second output idle in whole mode
    a_r2_b_idle_whole: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.split && !cfg.reg_en) |-> (out_b == 1'b0));

    // R7: registered output lags the lookup by one edge
    a_r7_reg_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.reg_en && $past(cfg.reg_en) && $stable(cfg.tt)) |->
            (out_a == $past(look.a) && out_b == $past(look.b)));

    // R3: top input has no effect in split mode
    a_r3_top_input_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.split && !cfg.reg_en && $past(cfg.split) && $past(!cfg.reg_en) &&
         $stable(lo) && $stable(cfg.tt)) |-> ($stable(out_a) && $stable(out_b)));
endmodule

// File: rtl/flut_cluster.sv
module flut_cluster
    import flut_pkg::*;
#(
    parameter int NUM_LUT = 8,
    localparam int LUT_AW = (NUM_LUT > 1) ? $clog2(NUM_LUT) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BUS_W-1:0]     blk_in,
    input  logic                 cfg_we,
    input  logic [LUT_AW-1:0]    cfg_lut,
    input  logic [WORD_AW-1:0]   cfg_word,
    input  logic [CFG_DW-1:0]    cfg_data,
    input  logic                 cfg_commit,
    output logic [NUM_LUT-1:0]   out_a,
    output logic [NUM_LUT-1:0]   out_b
);
    logic [NUM_LUT-1:0] sel_we;

    for (genvar i = 0; i < NUM_LUT; i++) begin : g_lut
        lut_cfg_t cfg_act;

        assign sel_we[i] = cfg_we && (cfg_lut == LUT_AW'(i));

        flut_cfg_store u_store (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (sel_we[i]),
            .word   (cfg_word),
            .data   (cfg_data),
            .commit (cfg_commit),
            .active (cfg_act)
        );

        flut_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .cfg    (cfg_act),
            .blk_in (blk_in),
            .out_a  (out_a[i]),
            .out_b  (out_b[i])
        );
    end

    // R6: at most one table is addressed per write
    a_r6_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_we));

    // R1: outputs read zero in the first cycle after reset
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (out_a == '0 && out_b == '0));
endmodule

// File: tb/flut_cluster_test.sv
module flut_cluster_test;
    localparam int PERIOD = 10;
    localparam int NL = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] blk_in = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_lut = '0;
    logic [2:0]  cfg_word = '0;
    logic [15:0] cfg_data = '0;
    logic        cfg_commit = 1'b0;
    logic [NL-1:0] out_a, out_b;

    int total = 0;
    int bad = 0;

    logic [63:0] s_tt [NL];
    logic        s_sp [NL];
    logic        s_rg [NL];
    logic [3:0]  s_sel [NL][6];
    logic [63:0] a_tt [NL];
    logic        a_sp [NL];
    logic        a_rg [NL];
    logic [3:0]  a_sel [NL][6];

    always #(PERIOD/2) clk = ~clk;

    flut_cluster uut (
        .clk(clk), .rst_n(rst_n), .blk_in(blk_in), .cfg_we(cfg_we),
        .cfg_lut(cfg_lut), .cfg_word(cfg_word), .cfg_data(cfg_data),
        .cfg_commit(cfg_commit), .out_a(out_a), .out_b(out_b)
    );

    function automatic logic [1:0] ev(input logic [63:0] tt, input logic sp,
                                      input logic [5:0] x);
        if (sp) return {tt[{1'b0, x[4:0]}], tt[{1'b1, x[4:0]}]};
        return {tt[x], 1'b0};
    endfunction

    function automatic logic [1:0] expect_lut(input int i, input logic [15:0] bus);
        logic [5:0] x;
        for (int k = 0; k < 6; k++) x[k] = bus[a_sel[i][k]];
        return ev(a_tt[i], a_sp[i], x);
    endfunction

    task automatic chk(input string req, input int i, input logic [1:0] got,
                       input logic [1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s lut %0d: got %b expected %b", req, i, got, exp);
        end
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    task automatic wr(input int i, input int w, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_lut = 3'(i); cfg_word = 3'(w); cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (w < 4) s_tt[i][w*16 +: 16] = d;
        else if (w == 4) begin s_sp[i] = d[0]; s_rg[i] = d[1]; end
        else if (w == 5) for (int k = 0; k < 4; k++) s_sel[i][k] = d[k*4 +: 4];
        else if (w == 6) for (int k = 4; k < 6; k++) s_sel[i][k] = d[(k-4)*4 +: 4];
    endtask

    task automatic commit;
        @(negedge clk);
        cfg_commit = 1'b1;
        @(negedge clk);
        cfg_commit = 1'b0;
        for (int i = 0; i < NL; i++) begin
            a_tt[i] = s_tt[i]; a_sp[i] = s_sp[i]; a_rg[i] = s_rg[i];
            for (int k = 0; k < 6; k++) a_sel[i][k] = s_sel[i][k];
        end
        // let output registers refill under the new set
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic load(input int i, input logic [63:0] tt, input logic sp,
                        input logic rg, input logic [3:0] sl [6]);
        for (int w = 0; w < 4; w++) wr(i, w, tt[w*16 +: 16]);
        wr(i, 4, {14'd0, rg, sp});
        wr(i, 5, {sl[3], sl[2], sl[1], sl[0]});
        wr(i, 6, {8'd0, sl[5], sl[4]});
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < NL; i++)
            chk(req, i, {out_a[i], out_b[i]}, expect_lut(i, blk_in));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R6: got hang expected finish");
        summary;
        $finish;
    end

    initial begin
        logic [3:0] sl [6];
        logic [15:0] prev;
        void'($urandom(32'd7321));
        for (int i = 0; i < NL; i++) begin
            s_tt[i] = '0; s_sp[i] = 0; s_rg[i] = 0;
            a_tt[i] = '0; a_sp[i] = 0; a_rg[i] = 0;
            for (int k = 0; k < 6; k++) begin s_sel[i][k] = '0; a_sel[i][k] = '0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state under several bus values
        for (int n = 0; n < 4; n++) begin
            blk_in = 16'($urandom);
            #1;
            for (int i = 0; i < NL; i++) chk("R1", i, {out_a[i], out_b[i]}, 2'b00);
            @(negedge clk);
        end

        // R6/R5: shadow writes stay hidden until commit
        blk_in = 16'hFFFF;
        for (int k = 0; k < 6; k++) sl[k] = 4'(k);
        load(2, 64'h8000_0000_0000_0000, 1'b0, 1'b0, sl);
        #1;
        chk("R6", 2, {out_a[2], out_b[2]}, 2'b00);
        commit;
        #1;
        chk("R5", 2, {out_a[2], out_b[2]}, 2'b10);
        blk_in = 16'h001F;
        #1;
        chk("R5", 2, {out_a[2], out_b[2]}, 2'b00);

        // R9: word 7 writes leave every output untouched
        wr(2, 7, 16'hFFFF);
        wr(5, 7, 16'hAAAA);
        commit;
        for (int n = 0; n < 6; n++) begin
            blk_in = 16'($urandom);
            #1;
            check_all("R9");
            @(negedge clk);
        end

        // random configurations and patterns
        for (int r = 0; r < 40; r++) begin
            for (int i = 0; i < NL; i++) begin
                for (int k = 0; k < 6; k++) sl[k] = 4'($urandom);
                load(i, {32'($urandom), 32'($urandom)}, 1'($urandom), 1'($urandom), sl);
            end
            // R6: nothing changed before commit
            #1;
            check_all("R6");
            commit;
            prev = blk_in;
            for (int v = 0; v < 20; v++) begin
                @(negedge clk);
                blk_in = (v % 5 == 4) ? (prev ^ 16'h0001 << $urandom_range(15)) : 16'($urandom);
                #1;
                for (int i = 0; i < NL; i++) begin
                    if (a_rg[i])
                        chk("R7", i, {out_a[i], out_b[i]}, expect_lut(i, prev));
                    else
                        chk(a_sp[i] ? "R8 R3 R4" : "R8 R2 R4", i,
                            {out_a[i], out_b[i]}, expect_lut(i, blk_in));
                end
                @(posedge clk);
                #1;
                for (int i = 0; i < NL; i++)
                    if (a_rg[i])
                        chk("R7", i, {out_a[i], out_b[i]}, expect_lut(i, blk_in));
                prev = blk_in;
            end
        end

        // R3: directed flip of x5 in split mode
        for (int k = 0; k < 6; k++) sl[k] = 4'(k);
        load(0, 64'hF0F0_1234_0F0F_ABCD, 1'b1, 1'b0, sl);
        commit;
        blk_in = 16'h0013;
        #1;
        chk("R3", 0, {out_a[0], out_b[0]}, ev(64'hF0F0_1234_0F0F_ABCD, 1'b1, 6'h13));
        blk_in = 16'h0033;
        #1;
        chk("R3", 0, {out_a[0], out_b[0]}, ev(64'hF0F0_1234_0F0F_ABCD, 1'b1, 6'h13));

        // R10: thermometer to binary count
        for (int b = 0; b < 3; b++) begin
            logic [63:0] t;
            for (int e = 0; e < 64; e++) t[e] = 1'(($countones(6'(e)) >> b) & 1);
            load(b, t, 1'b0, 1'b0, sl);
        end
        commit;
        for (int c = 0; c <= 6; c++) begin
            @(negedge clk);
            blk_in = 16'((1 << c) - 1);
            #1;
            total++;
            if ({out_a[2], out_a[1], out_a[0]} !== 3'(c)) begin
                bad++;
                $display("FAIL R10 code %0d: got %0d expected %0d", c,
                         {out_a[2], out_a[1], out_a[0]}, c);
            end
        end

        summary;
        $finish;
    end
endmodule